// File: doc/BRIEF.md
# I2C Target Register Interface

This block is the target side of a two-wire I2C bus that fronts a small bank of 16-bit registers. SCL and SDA arrive already synchronized to a fast system clock. The block oversamples them to find clock edges and START, repeated START and STOP conditions. It matches a 7-bit device address and pulls SDA low through an open-drain output enable to acknowledge or to send data. A controller selects a register by sending a one-byte pointer after the write address. The pointer persists, so later reads can omit it.

Write data is not placed in the bank straight away. The two data bytes collect in a staging buffer, and the register changes only when the controller closes the transaction with STOP. This keeps an interrupted or restarted transfer from leaving a half-updated register. A pointer-only write followed by a repeated START and a read address gives a read from a chosen register. A read with no pointer byte returns the register the pointer already selects. The pointer never advances by itself.

Top module: `i2c_regbank_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START at any point, including in the middle of a byte, restarts address reception. A STOP at any point ends the transfer.
- R2: The address byte carries the 7-bit device address MSB first, then a direction bit (0 = write, 1 = read). When the address matches, the block acknowledges by holding SDA low for the whole of the ninth SCL high phase.
- R3: A non-matching address byte is not acknowledged. SDA then stays released for every following byte until the next START or STOP.
- R4: A write sends a pointer byte and then two data bytes, most significant first, and each is acknowledged. Any further byte in the same write is not acknowledged.
- R5: A register changes only when STOP follows a write that delivered both data bytes. A read that begins before that STOP returns the old value.
- R6: A START discards any staged write data. A STOP that arrives before both data bytes are complete discards them, and the register keeps its old value.
- R7: A write that carries only the pointer byte, followed by a repeated START and a read address, reads the register that pointer selects.
- R8: A read that starts without a pointer byte transmits the register selected by the pointer left by earlier transactions, high byte first, MSB first within each byte.
- R9: A not-acknowledge (SDA high) from the controller after any read byte ends transmission. SDA then stays released until START or STOP.
- R10: An acknowledge from the controller after the low byte makes the block send the same register again, starting from its high byte. The pointer does not change.
- R11: A pointer at or above the number of implemented registers is still acknowledged. Writes through it change no register, and reads through it return 0x0000.
- R12: The SDA output enable changes only while SCL is low. Received bits are taken on the rising edge of SCL.
- R13: While reset is held and after it is released, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| sda_oe | output | 1 | When 1, SDA is pulled low; when 0, SDA is released |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- the output enable moves only in SCL low phases;
- SDA stays quiet while the target ignores the bus or waits for the end of a transaction;
- nothing is driven outside the acknowledge slot while bytes are received;
- bank writes happen only on the cycle after STOP and only inside the implemented range;
- the staging buffer is empty after a START;
- the pointer is held steady while data is sent.

Other behaviour needs whole transactions, and only the bench scenarios can show it:
- the returned values;
- that data is staged rather than written early;
- a partial write and an unmatched address leave no trace;
- a repeated read resends the same word;
- the read-back of out-of-range pointers.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_DEVADDR,
    TS_PTR,
    TS_WR_HI,
    TS_WR_LO,
    TS_RD_HI,
    TS_RD_LO,
    TS_QUIET
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  // previous-sample registers; the idle bus level is high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [WORD_W-1:0] mem [NUM_REGS];
  logic              w_ok;
  logic              r_ok;
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  ridx;

  assign w_ok = waddr < ADDR_W'(NUM_REGS);
  assign r_ok = raddr < ADDR_W'(NUM_REGS);
  assign widx = waddr[IDX_W-1:0];
  assign ridx = raddr[IDX_W-1:0];

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && w_ok) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= r_ok ? mem[ridx] : '0;
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < ADDR_W'(NUM_REGS)));  // R11
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         NUM_REGS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PTR_W = BYTE_W;

  logic scl_rise, scl_fall, start_det, stop_det;

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              rw_q;
  logic              mst_ack;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] stage_hi;
  logic [BYTE_W-1:0] stage_lo;
  logic [1:0]        stage_n;
  logic              wr_en;
  logic [WORD_W-1:0] rd_word;
  logic              active;
  logic              ptr_ok;

  i2c_line_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (PTR_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (ptr),
    .wdata ({stage_hi, stage_lo}),
    .raddr (ptr),
    .rdata (rd_word)
  );

  assign active = (state != TS_IDLE) && (state != TS_QUIET);
  assign ptr_ok = ptr < PTR_W'(NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TS_IDLE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rw_q     <= 1'b0;
      mst_ack  <= 1'b0;
      ptr      <= '0;
      stage_hi <= '0;
      stage_lo <= '0;
      stage_n  <= '0;
      wr_en    <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= TS_DEVADDR;
        bit_cnt <= '0;
        stage_n <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= TS_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        stage_n <= '0;
        wr_en   <= (stage_n == 2'd2) && ptr_ok;
      end else if (active) begin
        if (scl_rise) begin
          if (bit_cnt < CNT_W'(8)) rx_sr <= {rx_sr[BYTE_W-2:0], sda_i};
          if (bit_cnt == CNT_W'(8)) mst_ack <= ~sda_i;
          if (bit_cnt != CNT_W'(9)) bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall) begin
          if (bit_cnt == CNT_W'(8)) begin
            // eighth bit finished: open the acknowledge slot
            case (state)
              TS_DEVADDR: begin
                if (rx_sr[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw_q   <= rx_sr[0];
                end else begin
                  state <= TS_QUIET;
                end
              end
              TS_PTR: begin
                ptr    <= rx_sr;
                sda_oe <= 1'b1;
              end
              TS_WR_HI: begin
                stage_hi <= rx_sr;
                stage_n  <= 2'd1;
                sda_oe   <= 1'b1;
              end
              TS_WR_LO: begin
                stage_lo <= rx_sr;
                stage_n  <= 2'd2;
                sda_oe   <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bit_cnt == CNT_W'(9)) begin
            // acknowledge slot finished: move to the next byte
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            case (state)
              TS_DEVADDR: begin
                if (rw_q) begin
                  state  <= TS_RD_HI;
                  sda_oe <= ~rd_word[WORD_W-1];
                  tx_sr  <= {rd_word[WORD_W-2:BYTE_W], 1'b0};
                end else begin
                  state <= TS_PTR;
                end
              end
              TS_PTR:   state <= TS_WR_HI;
              TS_WR_HI: state <= TS_WR_LO;
              TS_WR_LO: state <= TS_QUIET;
              TS_RD_HI: begin
                if (mst_ack) begin
                  state  <= TS_RD_LO;
                  sda_oe <= ~rd_word[BYTE_W-1];
                  tx_sr  <= {rd_word[BYTE_W-2:0], 1'b0};
                end else begin
                  state <= TS_QUIET;
                end
              end
              TS_RD_LO: begin
                if (mst_ack) begin
                  state  <= TS_RD_HI;
                  sda_oe <= ~rd_word[WORD_W-1];
                  tx_sr  <= {rd_word[WORD_W-2:BYTE_W], 1'b0};
                end else begin
                  state <= TS_QUIET;
                end
              end
              default: state <= TS_QUIET;
            endcase
          end else if ((bit_cnt != '0) &&
                       ((state == TS_RD_HI) || (state == TS_RD_LO))) begin
            sda_oe <= ~tx_sr[BYTE_W-1];
            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));  // R12
  AST_QUIET_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((state == TS_QUIET) || (state == TS_IDLE)) |-> !sda_oe);  // R3
  AST_RX_DRIVE_IN_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (((state == TS_DEVADDR) || (state == TS_PTR) || (state == TS_WR_HI) ||
      (state == TS_WR_LO)) && (bit_cnt < CNT_W'(8))) |-> !sda_oe);  // R2
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(stop_det));  // R5
  AST_STAGE_EMPTY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    $past(start_det) |-> (stage_n == 2'd0));  // R6
  AST_PTR_HELD_IN_READ: assert property (@(posedge clk) disable iff (rst)
    ((state == TS_RD_HI) || (state == TS_RD_LO)) |-> $stable(ptr));  // R10
endmodule

// File: tb/tb_i2c_regbank_target.sv
module tb_i2c_regbank_target;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   viol = 0;
  logic oe_p = 1'b0;
  logic scl_p = 1'b1;

  assign sda_line = ~(m_low | sda_oe);
  always #2 clk = ~clk;

  i2c_regbank_target #(.DEV_ADDR(ADDR), .NUM_REGS(8)) dut (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if ((sda_oe !== oe_p) && scl_p) viol++;
      oe_p  = sda_oe;
      scl_p = scl;
    end
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      m_low = 1'b0; wt(HALF);
      scl = 1'b1;   wt(HALF);
    end else begin
      m_low = 1'b0; wt(HALF);
    end
    m_low = 1'b1; wt(HALF);
    scl = 1'b0;   wt(HALF);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF);
    m_low = 1'b0; wt(HALF);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_low = ~b;  wt(HALF);
    scl = 1'b1;  wt(HALF / 2);
    seen = sda_line;
    wt(HALF / 2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(!m_ack, s);
  endtask

  task automatic write_word(input logic [7:0] p, input logic [15:0] v, input logic do_stop,
                            output logic [3:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[3]);
    send_byte(p, acks[2]);
    send_byte(v[15:8], acks[1]);
    send_byte(v[7:0], acks[0]);
    if (do_stop) bus_stop();
  endtask

  task automatic read_imm(output logic [15:0] v, output logic ack);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    recv_byte(1'b1, v[15:8]);
    recv_byte(1'b0, v[7:0]);
    bus_stop();
  endtask

  task automatic read_sel(input logic [7:0] p, output logic [15:0] v, output logic [2:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    bus_start();
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(1'b1, v[15:8]);
    recv_byte(1'b0, v[7:0]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R13 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    wt(4);
    chk("R13 sda released after reset", {31'd0, sda_line}, 32'd1);
  endtask

  task automatic t_write_then_select();
    logic [3:0] a;
    logic [2:0] ra;
    logic [15:0] v;
    write_word(8'h02, 16'hA5C3, 1'b1, a);
    chk("R2 R4 write acks", {28'd0, a}, 32'hF);
    read_sel(8'h02, v, ra);
    chk("R7 select read acks", {29'd0, ra}, 32'h7);
    chk("R5 R7 committed value read back", {16'd0, v}, 32'hA5C3);
  endtask

  task automatic t_immediate();
    logic [15:0] v;
    logic a;
    read_imm(v, a);
    chk("R8 read address ack", {31'd0, a}, 32'd1);
    chk("R8 immediate read uses held pointer", {16'd0, v}, 32'hA5C3);
  endtask

  task automatic t_staging();
    logic [3:0] a;
    logic ra;
    logic [15:0] v;
    write_word(8'h02, 16'h1111, 1'b0, a);
    bus_start();
    send_byte({ADDR, 1'b1}, ra);
    recv_byte(1'b1, v[15:8]);
    recv_byte(1'b0, v[7:0]);
    bus_stop();
    chk("R5 value before STOP is old", {16'd0, v}, 32'hA5C3);
    read_imm(v, ra);
    chk("R6 START discarded staged write", {16'd0, v}, 32'hA5C3);
  endtask

  task automatic t_extra_byte();
    logic [3:0] a;
    logic x;
    logic [2:0] ra;
    logic [15:0] v;
    write_word(8'h05, 16'h0F0E, 1'b0, a);
    send_byte(8'h99, x);
    bus_stop();
    chk("R4 extra byte not acked", {31'd0, x}, 32'd0);
    read_sel(8'h05, v, ra);
    chk("R4 two-byte write MSB first", {16'd0, v}, 32'h0F0E);
  endtask

  task automatic t_abort();
    logic a;
    logic s;
    logic [15:0] v;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h05, a);
    send_byte(8'h77, a);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    bus_stop();
    read_imm(v, a);
    chk("R6 partial write discarded at STOP", {16'd0, v}, 32'h0F0E);
    bus_start();
    for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b1, v[15:8]);
    recv_byte(1'b0, v[7:0]);
    bus_stop();
    chk("R1 START mid-byte restarts address", {15'd0, a, v}, 32'h10F0E);
  endtask

  task automatic t_mismatch();
    logic a;
    logic b;
    logic [15:0] v;
    int lows = 0;
    bus_start();
    send_byte({7'h2D, 1'b0}, a);
    chk("R3 mismatched address not acked", {31'd0, a}, 32'd0);
    send_byte(8'h02, b);
    chk("R3 later byte not acked", {31'd0, b}, 32'd0);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, b);
      if (!b) lows++;
    end
    bus_stop();
    chk("R3 SDA stays released", lows, 0);
    read_imm(v, a);
    chk("R3 pointer untouched by ignored bytes", {16'd0, v}, 32'h0F0E);
  endtask

  task automatic t_reread();
    logic a;
    logic [7:0] b0, b1, b2, b3;
    logic [15:0] v;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b1, b2);
    recv_byte(1'b0, b3);
    bus_stop();
    chk("R10 first pass", {16'd0, b0, b1}, 32'h0F0E);
    chk("R10 resend from high byte", {16'd0, b2, b3}, 32'h0F0E);
    read_imm(v, a);
    chk("R10 pointer unchanged", {16'd0, v}, 32'h0F0E);
  endtask

  task automatic t_nack_high();
    logic a;
    logic s;
    logic [7:0] b0;
    int lows = 0;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b0, b0);
    chk("R9 high byte sent", {24'd0, b0}, 32'h0F);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      if (!s) lows++;
    end
    bus_stop();
    chk("R9 SDA released after NACK", lows, 0);
  endtask

  task automatic t_out_of_range();
    logic [3:0] a;
    logic ra;
    logic [2:0] rs;
    logic [15:0] v;
    write_word(8'h25, 16'h1234, 1'b1, a);
    chk("R11 out-of-range write acked", {28'd0, a}, 32'hF);
    read_imm(v, ra);
    chk("R11 out-of-range read is zero", {16'd0, v}, 32'h0000);
    read_sel(8'h05, v, rs);
    chk("R11 no alias write", {16'd0, v}, 32'h0F0E);
  endtask

  initial begin
    wt(5);
    t_reset();
    t_write_then_select();
    t_immediate();
    t_staging();
    t_extra_byte();
    t_abort();
    t_mismatch();
    t_reread();
    t_nack_high();
    t_out_of_range();
    chk("R12 output enable changes with SCL high", viol, 0);
    summary();
    $finish;
  end
endmodule